// File: doc/BRIEF.md
# Store-Release Exclusive Word Unit

This unit carries out a 32-bit exclusive store with release ordering. It holds a single local exclusive monitor: an earlier exclusive load arms it with a word address. A store request is accepted when the unit is idle. The monitor is checked against the store address in the cycle of acceptance. The outcome is then computed and held until it can be issued.

A store that passes the check and is word aligned is a real write. It is released only after the surrounding pipeline reports that all prior accesses have drained. In that same cycle the unit writes status 0 to the destination register. A store that fails the check writes status 1 and leaves memory alone. The unit also reports three other cases:

- a misaligned address that would otherwise have been written raises an alignment abort;
- an illegal register combination raises an undefined-instruction trap;
- a request whose condition failed produces only a completion pulse.

Every store whose condition passed empties the monitor. A data-independent-timing mode makes the failing, aborting and passing paths all wait for the drain, so that latency is uniform.

Top module: `srx_store_unit`

## Requirements
- R1: A legal, condition-passed store to a word-aligned address whose word matches the armed monitor issues `mem_wr_valid` with the store address, the store data and `mem_wr_bytes` = 4. In the same cycle it issues `st_wr_valid` with `st_wr_idx` = d and `st_wr_value` = 0.
- R2: A legal, condition-passed store whose word does not match an armed monitor, or that finds the monitor empty, writes no memory. It issues `st_wr_valid` with `st_wr_value` = 1.
- R3: A store with `req_cond_pass` = 0 produces only `done`: no memory write, no status write, no abort, no trap. The monitor contents are unchanged.
- R4: If d, t or n equals 15, `undef_trap` is raised with `done`, and neither memory nor the status register is written.
- R5: If d equals t or d equals n, the unit takes the undefined outcome: `undef_trap` is raised with no write of any kind.
- R6: A store that passes the monitor check but has a nonzero address[1:0] raises `abort_align` and writes neither memory nor the status register.
- R7: A store that fails the monitor check with a nonzero address[1:0] raises no abort and writes status 1.
- R8: Every store accepted with `req_cond_pass` = 1 empties the monitor, whatever its outcome, so a repeat store without a new mark fails.
- R9: A mark arms the monitor with address[31:2] of `mark_addr`; a later store matches on address[31:2] only.
- R10: `clrex` and reset empty the monitor in the cycle they are asserted. A mark in the same cycle as `clrex`, or as an accepted condition-passed store, is discarded. The store in that cycle is checked against the monitor contents from before the edge.
- R11: A real write waits in the hold state while `drained` is low. During that wait, `done` and the write strobes stay low, `req_ready` stays low and the write address and data stay stable. The write is issued in the first cycle `drained` is high.
- R12: With `dit_mode` = 1 at acceptance, every legal condition-passed outcome waits for `drained`, so latency does not depend on the monitor result or the data. With `dit_mode` = 0, a failing store completes one cycle after acceptance.
- R13: `req_ready` is high only when idle. Each accepted request yields exactly one `done` pulse, and `done` never coincides with `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Unit idle, request is taken this cycle |
| req_cond_pass | input | 1 | Condition check of the request passed |
| req_rd | input | 4 | Status destination register index d |
| req_rt | input | 4 | Data source register index t |
| req_rn | input | 4 | Base register index n |
| req_addr | input | 32 | Store address |
| req_data | input | 32 | Store data |
| dit_mode | input | 1 | Data-independent-timing mode |
| drained | input | 1 | Prior memory accesses have completed |
| mark_valid | input | 1 | Exclusive load arms the monitor |
| mark_addr | input | 32 | Address of the exclusive load |
| clrex | input | 1 | Clear the exclusive monitor |
| mem_wr_valid | output | 1 | Memory write strobe |
| mem_wr_addr | output | 32 | Memory write address |
| mem_wr_data | output | 32 | Memory write data |
| mem_wr_bytes | output | 3 | Access size in bytes (4) |
| st_wr_valid | output | 1 | Status register write strobe |
| st_wr_idx | output | 4 | Status register index |
| st_wr_value | output | 32 | Status value, 0 or 1 |
| abort_align | output | 1 | Alignment abort |
| undef_trap | output | 1 | Undefined-instruction trap |
| done | output | 1 | Request completed this cycle |

## Verification
Two kinds of monitor update can land on the same clock edge: arming by a mark, and emptying by `clrex` or by an accepted store. The bench drives a mark in the very cycle a store is accepted. It expects that store to be judged on the older monitor contents and the mark to be lost, which a following store then shows by failing. With `req_cond_pass` low instead, the same overlap must keep the mark, so the follow-up store passes. A mark together with `clrex` is likewise judged by a subsequent store failing.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic {
    SRX_IDLE = 1'b0,
    SRX_HOLD = 1'b1
  } srx_state_e;

  typedef struct packed {
    logic do_write;
    logic wr_status;
    logic status_one;
    logic abort;
    logic undef;
    logic need_drain;
  } srx_outcome_t;

endpackage

// File: rtl/srx_excl_monitor.sv
module srx_excl_monitor #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic [ADDR_W-1:0] arm_addr_i,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] probe_addr_i,
  output logic              hit_o
);
  localparam int TAG_W = ADDR_W - GRAN_BITS;

  logic             valid_q, valid_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             tag_en;
  logic             unused_low_bits;

  assign unused_low_bits = ^{arm_addr_i[GRAN_BITS-1:0], probe_addr_i[GRAN_BITS-1:0]};

  // clearing outranks arming in the same cycle
  always_comb begin
    valid_d = valid_q;
    tag_en  = 1'b0;
    tag_d   = arm_addr_i[ADDR_W-1:GRAN_BITS];
    if (clear_i) begin
      valid_d = 1'b0;
    end else if (arm_i) begin
      valid_d = 1'b1;
      tag_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tag_q <= '0;
    else if (tag_en) tag_q <= tag_d;
  end

  assign hit_o = valid_q && (tag_q == probe_addr_i[ADDR_W-1:GRAN_BITS]);
endmodule

// File: rtl/srx_reg_check.sv
module srx_reg_check #(
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15
) (
  input  logic [IDX_W-1:0] rd_i,
  input  logic [IDX_W-1:0] rt_i,
  input  logic [IDX_W-1:0] rn_i,
  output logic             illegal_o
);
  localparam logic [IDX_W-1:0] PC_CODE = IDX_W'(PC_IDX);

  logic [IDX_W-1:0] ops [3];
  logic [2:0]       is_pc;
  logic             overlap;

  assign ops[0] = rd_i;
  assign ops[1] = rt_i;
  assign ops[2] = rn_i;

  for (genvar g = 0; g < 3; g++) begin : g_pc
    assign is_pc[g] = (ops[g] == PC_CODE);
  end

  assign overlap   = (rd_i == rt_i) || (rd_i == rn_i);
  assign illegal_o = (|is_pc) || overlap;
endmodule

// File: rtl/srx_outcome_calc.sv
module srx_outcome_calc
  import srx_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             cond_pass_i,
  input  logic             illegal_i,
  input  logic             hit_i,
  input  logic [OFS_W-1:0] addr_low_i,
  input  logic             dit_i,
  output srx_outcome_t     out_o
);
  logic aligned;
  assign aligned = (addr_low_i == '0);

  // priority: condition, register legality, alignment under a pass, pass, fail
  always_comb begin
    out_o = '0;
    if (cond_pass_i) begin
      if (illegal_i) begin
        out_o.undef = 1'b1;
      end else if (hit_i && !aligned) begin
        out_o.abort = 1'b1;
      end else if (hit_i) begin
        out_o.do_write  = 1'b1;
        out_o.wr_status = 1'b1;
      end else begin
        out_o.wr_status  = 1'b1;
        out_o.status_one = 1'b1;
      end
      out_o.need_drain = !illegal_i && (out_o.do_write || dit_i);
    end
  end
endmodule

// File: rtl/srx_store_unit.sv
module srx_store_unit
  import srx_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int IDX_W        = 4,
  parameter int ACCESS_BYTES = 4,
  parameter int PC_IDX       = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_cond_pass,
  input  logic [IDX_W-1:0]  req_rd,
  input  logic [IDX_W-1:0]  req_rt,
  input  logic [IDX_W-1:0]  req_rn,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              dit_mode,
  input  logic              drained,
  input  logic              mark_valid,
  input  logic [ADDR_W-1:0] mark_addr,
  input  logic              clrex,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic [$clog2(ACCESS_BYTES):0] mem_wr_bytes,
  output logic              st_wr_valid,
  output logic [IDX_W-1:0]  st_wr_idx,
  output logic [DATA_W-1:0] st_wr_value,
  output logic              abort_align,
  output logic              undef_trap,
  output logic              done
);
  localparam int OFS_W   = $clog2(ACCESS_BYTES);
  localparam int BYTES_W = OFS_W + 1;

  srx_state_e   state_q, state_d;
  logic         accept, go, cap_en;
  logic         mon_hit, mon_clear, illegal;
  srx_outcome_t outcome, cap_out;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic [IDX_W-1:0]  cap_rd;

  assign accept    = req_valid && (state_q == SRX_IDLE);
  assign cap_en    = accept;
  assign mon_clear = clrex || (accept && req_cond_pass);

  srx_excl_monitor #(
    .ADDR_W   (ADDR_W),
    .GRAN_BITS(OFS_W)
  ) u_mon (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_i       (mark_valid),
    .arm_addr_i  (mark_addr),
    .clear_i     (mon_clear),
    .probe_addr_i(req_addr),
    .hit_o       (mon_hit)
  );

  srx_reg_check #(
    .IDX_W (IDX_W),
    .PC_IDX(PC_IDX)
  ) u_regs (
    .rd_i     (req_rd),
    .rt_i     (req_rt),
    .rn_i     (req_rn),
    .illegal_o(illegal)
  );

  srx_outcome_calc #(
    .OFS_W(OFS_W)
  ) u_calc (
    .cond_pass_i(req_cond_pass),
    .illegal_i  (illegal),
    .hit_i      (mon_hit),
    .addr_low_i (req_addr[OFS_W-1:0]),
    .dit_i      (dit_mode),
    .out_o      (outcome)
  );

  assign go = (state_q == SRX_HOLD) && (!cap_out.need_drain || drained);

  always_comb begin
    state_d = state_q;
    case (state_q)
      SRX_IDLE: if (accept) state_d = SRX_HOLD;
      SRX_HOLD: if (go)     state_d = SRX_IDLE;
      default:              state_d = SRX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SRX_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_out  <= '0;
      cap_addr <= '0;
      cap_data <= '0;
      cap_rd   <= '0;
    end else if (cap_en) begin
      cap_out  <= outcome;
      cap_addr <= req_addr;
      cap_data <= req_data;
      cap_rd   <= req_rd;
    end
  end

  assign req_ready    = (state_q == SRX_IDLE);
  assign done         = go;
  assign mem_wr_valid = go && cap_out.do_write;
  assign mem_wr_addr  = cap_addr;
  assign mem_wr_data  = cap_data;
  assign mem_wr_bytes = BYTES_W'(ACCESS_BYTES);
  assign st_wr_valid  = go && cap_out.wr_status;
  assign st_wr_idx    = cap_rd;
  assign st_wr_value  = {{(DATA_W-1){1'b0}}, cap_out.status_one};
  assign abort_align  = go && cap_out.abort;
  assign undef_trap   = go && cap_out.undef;
endmodule

// File: rtl/srx_store_unit_chk.sv
module srx_store_unit_chk #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int BYTES_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              drained,
  input logic              req_ready,
  input logic              done,
  input logic              mem_wr_valid,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic [BYTES_W-1:0] mem_wr_bytes,
  input logic              st_wr_valid,
  input logic [DATA_W-1:0] st_wr_value,
  input logic              abort_align,
  input logic              undef_trap
);
  AST_WRITE_PAIRS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (st_wr_valid && st_wr_value == '0 && mem_wr_bytes == BYTES_W'(4))); // R1

  AST_STATUS_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_valid |-> (st_wr_value <= DATA_W'(1))); // R2

  AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    undef_trap |-> (!mem_wr_valid && !st_wr_valid && !abort_align)); // R4

  AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_align |-> (!mem_wr_valid && !st_wr_valid)); // R6

  AST_WRITE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> drained); // R11

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !done) |=> ($stable(mem_wr_addr) && $stable(mem_wr_data))); // R11

  AST_DONE_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready); // R13

  AST_STROBES_NEED_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid || st_wr_valid || abort_align || undef_trap) |-> done); // R13
endmodule

bind srx_store_unit srx_store_unit_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .BYTES_W($clog2(ACCESS_BYTES) + 1)
) chk_i (.*);

// File: tb/srx_store_unit_tb_top.sv
`timescale 1ns/1ps
module srx_store_unit_tb_top;
  logic        clk, rst_n;
  logic        req_valid, req_ready, req_cond_pass;
  logic [3:0]  req_rd, req_rt, req_rn;
  logic [31:0] req_addr, req_data;
  logic        dit_mode, drained, mark_valid, clrex;
  logic [31:0] mark_addr;
  logic        mem_wr_valid, st_wr_valid, abort_align, undef_trap, done;
  logic [31:0] mem_wr_addr, mem_wr_data, st_wr_value;
  logic [2:0]  mem_wr_bytes;
  logic [3:0]  st_wr_idx;

  srx_store_unit dut_i (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    bit wr; bit st; bit st1; bit ab; bit ud;
    logic [31:0] addr; logic [31:0] data; logic [3:0] rd;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   mon_v;
  logic [29:0] mon_tag;

  task automatic check(input bit ok, input string req, input string msg);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (rst_n && done) begin
      if (q.size() == 0) begin
        check(0, "R13", "done with no pending item (actual done=1 expected 0)");
      end else begin
        exp_t e;
        bit ok;
        e = q.pop_front();
        ok = (mem_wr_valid == e.wr) && (st_wr_valid == e.st) &&
             (abort_align == e.ab) && (undef_trap == e.ud);
        if (e.wr) ok = ok && (mem_wr_addr == e.addr) && (mem_wr_data == e.data) && (mem_wr_bytes == 3'd4);
        if (e.st) ok = ok && (st_wr_idx == e.rd) && (st_wr_value == {31'b0, e.st1});
        check(ok, e.req, $sformatf(
          "actual wr=%0b st=%0b val=%0h ab=%0b ud=%0b addr=%0h data=%0h expected wr=%0b st=%0b val=%0h ab=%0b ud=%0b addr=%0h data=%0h",
          mem_wr_valid, st_wr_valid, st_wr_value, abort_align, undef_trap, mem_wr_addr, mem_wr_data,
          e.wr, e.st, e.st1, e.ab, e.ud, e.addr, e.data));
      end
    end
  end

  task automatic do_mark(input logic [31:0] a);
    @(negedge clk);
    mark_valid = 1'b1; mark_addr = a;
    @(negedge clk);
    mark_valid = 1'b0;
    mon_v = 1'b1; mon_tag = a[31:2];
  endtask

  task automatic do_clear(input bit with_mark, input logic [31:0] a);
    @(negedge clk);
    clrex = 1'b1; mark_valid = with_mark; mark_addr = a;
    @(negedge clk);
    clrex = 1'b0; mark_valid = 1'b0;
    mon_v = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(req_ready == 1'b1 && done == 1'b0 && mem_wr_valid == 1'b0, "R10",
          $sformatf("reset state actual ready=%0b done=%0b wr=%0b expected 1 0 0", req_ready, done, mem_wr_valid));
    @(negedge clk);
    rst_n = 1'b1;
    mon_v = 1'b0;
  endtask

  task automatic do_store(input bit cond, input logic [3:0] rd, input logic [3:0] rt, input logic [3:0] rn,
                          input logic [31:0] a, input logic [31:0] d, input bit dit, input int delay,
                          input bit mark_same, input logic [31:0] ma, input string req);
    exp_t e;
    bit illegal, hit, need;
    int exp_lat;
    bit seen;
    illegal = (rd == 15) || (rt == 15) || (rn == 15) || (rd == rt) || (rd == rn);
    hit = mon_v && (mon_tag == a[31:2]);
    e.wr = 0; e.st = 0; e.st1 = 0; e.ab = 0; e.ud = 0;
    e.addr = a; e.data = d; e.rd = rd; e.req = req;
    if (cond) begin
      if (illegal)                 e.ud = 1;
      else if (hit && a[1:0] != 0) e.ab = 1;
      else if (hit)                begin e.wr = 1; e.st = 1; end
      else                         begin e.st = 1; e.st1 = 1; end
    end
    need = cond && !illegal && (e.wr || dit);
    exp_lat = need ? delay + 1 : 1;
    if (cond) mon_v = 1'b0;
    else if (mark_same) begin mon_v = 1'b1; mon_tag = ma[31:2]; end
    q.push_back(e);

    @(negedge clk);
    check(req_ready == 1'b1, "R13", $sformatf("ready before request actual %0b expected 1", req_ready));
    req_valid = 1'b1; req_cond_pass = cond; req_rd = rd; req_rt = rt; req_rn = rn;
    req_addr = a; req_data = d; dit_mode = dit; drained = 1'b0;
    mark_valid = mark_same; mark_addr = ma;
    seen = 0;
    for (int k = 1; k <= 40 && !seen; k++) begin
      @(negedge clk);
      if (k == 1) begin
        req_valid = 1'b0; mark_valid = 1'b0;
        req_data = ~d; req_addr = ~a;
      end
      drained = (k > delay);
      #1;
      if (done) begin
        seen = 1;
        check(k == exp_lat, need ? "R11" : "R12",
              $sformatf("%s latency actual %0d expected %0d", req, k, exp_lat));
      end else if (need && k <= delay) begin
        check(!req_ready && !mem_wr_valid && !st_wr_valid, "R11",
              $sformatf("stall actual ready=%0b wr=%0b st=%0b expected 0 0 0", req_ready, mem_wr_valid, st_wr_valid));
      end
    end
    if (!seen) check(0, "R13", $sformatf("%s no done actual 0 expected 1", req));
    drained = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_cond_pass = 0; req_rd = 0; req_rt = 0; req_rn = 0;
    req_addr = 0; req_data = 0; dit_mode = 0; drained = 1; mark_valid = 0; mark_addr = 0; clrex = 0;
    mon_v = 0; mon_tag = 0;
    repeat (3) @(negedge clk);
    #1;
    check(req_ready == 1'b1 && done == 1'b0 && mem_wr_valid == 1'b0 && st_wr_valid == 1'b0, "R13",
          $sformatf("reset outputs actual ready=%0b done=%0b expected 1 0", req_ready, done));
    @(negedge clk);
    rst_n = 1'b1;

    do_store(1, 1, 2, 3, 32'h100, 32'h1111, 0, 0, 0, 0, "R2 empty monitor");
    do_mark(32'h100);
    do_store(1, 1, 2, 3, 32'h100, 32'hA5A5_5A5A, 0, 3, 0, 0, "R1 R11 pass after drain");
    do_store(1, 1, 2, 3, 32'h100, 32'h2222, 0, 0, 0, 0, "R8 repeat fails");
    do_mark(32'h103);
    do_store(1, 4, 5, 6, 32'h100, 32'h3333, 0, 0, 0, 0, "R9 same word passes");
    do_mark(32'h100);
    do_store(1, 4, 5, 6, 32'h104, 32'h4444, 0, 0, 0, 0, "R9 next word fails");
    do_mark(32'h200);
    do_store(0, 1, 2, 3, 32'h200, 32'h5555, 0, 0, 0, 0, "R3 condition fail");
    do_store(1, 1, 2, 3, 32'h200, 32'h6666, 0, 0, 0, 0, "R3 monitor kept");
    do_mark(32'h300);
    do_store(1, 15, 2, 3, 32'h300, 32'h7777, 0, 0, 0, 0, "R4 d is 15");
    do_store(1, 1, 2, 3, 32'h300, 32'h7778, 0, 0, 0, 0, "R8 cleared by illegal");
    do_mark(32'h300);
    do_store(1, 1, 2, 15, 32'h300, 32'h7779, 0, 0, 0, 0, "R4 n is 15");
    do_mark(32'h300);
    do_store(1, 2, 2, 3, 32'h300, 32'h8888, 0, 0, 0, 0, "R5 d equals t");
    do_mark(32'h300);
    do_store(1, 3, 2, 3, 32'h300, 32'h8889, 0, 0, 0, 0, "R5 d equals n");
    do_mark(32'h400);
    do_store(1, 1, 2, 3, 32'h402, 32'h9999, 0, 0, 0, 0, "R6 misaligned pass aborts");
    do_store(1, 1, 2, 3, 32'h402, 32'h9998, 0, 0, 0, 0, "R7 misaligned fail no abort");
    do_mark(32'h500);
    do_clear(0, 0);
    do_store(1, 1, 2, 3, 32'h500, 32'hAAAA, 0, 0, 0, 0, "R10 clrex");
    do_clear(1, 32'h500);
    do_store(1, 1, 2, 3, 32'h500, 32'hAAAB, 0, 0, 0, 0, "R10 clrex beats mark");
    do_mark(32'h500);
    do_reset();
    do_store(1, 1, 2, 3, 32'h500, 32'hAAAC, 0, 0, 0, 0, "R10 reset clears");
    do_mark(32'h600);
    do_store(1, 1, 2, 3, 32'h600, 32'hBBBB, 0, 0, 1, 32'h700, "R10 store with mark uses old");
    do_store(1, 1, 2, 3, 32'h700, 32'hBBBC, 0, 0, 0, 0, "R10 mark lost to store");
    do_store(0, 1, 2, 3, 32'h700, 32'hBBBD, 0, 0, 1, 32'h700, "R3 cond fail with mark");
    do_store(1, 1, 2, 3, 32'h700, 32'hBBBE, 0, 0, 0, 0, "R10 mark kept on cond fail");
    do_store(1, 1, 2, 3, 32'h800, 32'h0, 1, 4, 0, 0, "R12 dit fail waits");
    do_mark(32'h800);
    do_store(1, 1, 2, 3, 32'h800, 32'h0, 1, 4, 0, 0, "R12 dit pass zero data");
    do_mark(32'h800);
    do_store(1, 1, 2, 3, 32'h800, 32'hFFFF_FFFF, 1, 4, 0, 0, "R12 dit pass ones data");
    do_store(1, 1, 2, 3, 32'h800, 32'h1234, 0, 4, 0, 0, "R12 no dit fail fast");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R13", $sformatf("pending items actual %0d expected 0", q.size()));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule